// File: doc/BRIEF.md
# Display-List Launch Control Register Block

This block sits on a byte-wide host register bus and governs when a display-list interpreter runs. It starts out locked. While locked it accepts no register contents. The host has to write a two-byte key to the control offset, the two writes back to back, before any register can be written. Once open, the control register selects the memory bank that host ports use and carries a run request. It also carries a two-bit port mode. Two further registers hold the 16-bit address where the interpreter begins. A launch register starts the interpreter on the next cycle when it is written. When it is read, it returns a version and a video-timing code.

Two state machines make the decisions. The key machine has the states `LK_IDLE`, `LK_HALF` and `LK_OPEN`. It moves from `LK_IDLE` to `LK_HALF` on a control write of 0x42. It moves from `LK_HALF` to `LK_OPEN` when the very next write is 0x52 to the control offset. Any other write in `LK_HALF` returns it to `LK_IDLE`. `LK_OPEN` is left only through reset. The run machine has the states `RUN_OFF`, `RUN_ARMED` and `RUN_LIVE`. An arm write takes `RUN_OFF` to `RUN_ARMED`. A frame-start pulse takes `RUN_ARMED` to `RUN_LIVE` and issues a restart. A launch write takes any state to `RUN_LIVE` with a restart. A stop write takes any state to `RUN_OFF` and loads the execution bank. In `RUN_LIVE`, every frame start issues another restart.

The interpreter itself lies outside the block. It sees only `eng_run`, the one-cycle `eng_restart` pulse, the start address and the execution bank.

Top module: `dl_launch_ctrl`

## Requirements
- R1: After reset the block is locked. The control byte, both address bytes, `eng_start_addr`, `eng_exec_bank`, `host_bank` and `port_copy` are all zero. `eng_run` and `eng_restart` are low.
- R2: While locked, writes to any offset leave every register and output unchanged, including a launch write. The block opens only after 0x42 and then 0x52 are written to offset 0 on two consecutive bus writes. Neither key byte is stored.
- R3: A second write that is not 0x52 to offset 0, for example 0x53 to offset 0 or any write to offset 1, drops the key sequence back to idle. The open state then holds until reset.
- R4: The control byte (offset 0) reads back as written. Its bits [2:0] drive `host_bank`.
- R5: A control write with bit 3 = 1 does not raise `eng_run`. The run starts at the first `frame_start` pulse after it. On the cycle after that pulse, `eng_run` and `eng_restart` are both high.
- R6: A control write with bit 3 = 0 lowers `eng_run` from the next cycle and loads `eng_exec_bank` from bits [2:0] of the write. No other write changes `eng_exec_bank`.
- R7: Offset 1 holds the start address low byte and offset 2 holds the high byte. Both read back as written and together form `eng_start_addr`.
- R8: Any write to offset 3 (launch) raises `eng_run` and `eng_restart` on the following cycle, whether or not the run was armed. `eng_restart` lasts one cycle.
- R9: A read of offset 3 returns the version (parameter, default 3) in bits [7:3] and `vid_std` in bits [2:0]. The four codes 000, 110, 100 and 011 each pass through unchanged.
- R10: `port_copy` is high only when control bits [7:6] equal 01. The values 00, 10 and 11 give low.
- R11: While running, each `frame_start` pulse produces a one-cycle `eng_restart` on the next cycle, and `eng_run` stays high.
- R12: A stop write in the same cycle as `frame_start` wins. No restart follows and `eng_run` goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register offset |
| bus_we | input | 1 | Write enable for one cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| vid_std | input | 3 | Video-timing configuration code |
| frame_start | input | 1 | One-cycle pulse at the start of each frame |
| eng_run | output | 1 | Interpreter may execute |
| eng_restart | output | 1 | One-cycle pulse: begin at `eng_start_addr` |
| eng_start_addr | output | START_W | Start address for the interpreter |
| eng_exec_bank | output | 3 | Memory bank for interpreter execution |
| host_bank | output | 3 | Memory bank for host port accesses |
| port_copy | output | 1 | Port 0 writes are mirrored to port 1 |

## Verification
A key machine stuck in the wrong state shows at once. Either a control write after the key does not read back at the next read, or a control write before the key does read back. A run machine in the wrong state shows within one cycle of the next `frame_start` or launch write, as a missing or extra `eng_restart`, or as `eng_run` at the wrong level. A wrong execution bank is visible on `eng_exec_bank` on the cycle after the stop write that should have set it.

// File: rtl/dl_launch_pkg.sv
package dl_launch_pkg;

    // key bytes, in the order they must arrive
    localparam logic [7:0] KEY_FIRST  = 8'h42;
    localparam logic [7:0] KEY_SECOND = 8'h52;

    // register offsets; start-address bytes follow the control byte,
    // the launch register follows the last address byte
    localparam int OFS_CTRL  = 0;
    localparam int OFS_START = 1;

    localparam int BANK_W = 3;

    localparam logic [1:0] PMODE_NORMAL = 2'b00;
    localparam logic [1:0] PMODE_COPY   = 2'b01;

    typedef enum logic [1:0] {
        LK_IDLE,
        LK_HALF,
        LK_OPEN
    } unlock_state_e;

    typedef enum logic [1:0] {
        RUN_OFF,
        RUN_ARMED,
        RUN_LIVE
    } run_state_e;

    typedef struct packed {
        logic [1:0]        port_mode;
        logic [1:0]        spare;
        logic              run_req;
        logic [BANK_W-1:0] bank;
    } ctrl_t;

endpackage

// File: rtl/dl_unlock_fsm.sv
module dl_unlock_fsm
    import dl_launch_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_any,
    input  logic       wr_ctrl,
    input  logic [7:0] wdata,
    output logic       unlocked
);

    unlock_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LK_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_IDLE: begin
                if (wr_ctrl && wdata == KEY_FIRST) state_d = LK_HALF;
            end
            LK_HALF: begin
                // the very next write decides: right byte opens, anything else resets
                if (wr_any) begin
                    if (wr_ctrl && wdata == KEY_SECOND) state_d = LK_OPEN;
                    else                                state_d = LK_IDLE;
                end
            end
            LK_OPEN: state_d = LK_OPEN;
            default: state_d = LK_IDLE;
        endcase
    end

    always_comb begin
        unlocked = (state_q == LK_OPEN);
    end

endmodule

// File: rtl/dl_run_fsm.sv
module dl_run_fsm
    import dl_launch_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stop_req,
    input  logic              arm_req,
    input  logic              launch_req,
    input  logic              frame_start,
    input  logic [BANK_W-1:0] bank_in,
    output logic              run,
    output logic              restart,
    output logic [BANK_W-1:0] exec_bank
);

    run_state_e        state_q, state_d;
    logic              restart_d, restart_q;
    logic [BANK_W-1:0] bank_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RUN_OFF;
        else        state_q <= state_d;
    end

    // stop outranks launch and frame start; launch outranks the frame
    always_comb begin
        state_d   = state_q;
        restart_d = 1'b0;
        if (stop_req) begin
            state_d = RUN_OFF;
        end else if (launch_req) begin
            state_d   = RUN_LIVE;
            restart_d = 1'b1;
        end else begin
            unique case (state_q)
                RUN_OFF: begin
                    if (arm_req) state_d = RUN_ARMED;
                end
                RUN_ARMED: begin
                    if (frame_start) begin
                        state_d   = RUN_LIVE;
                        restart_d = 1'b1;
                    end
                end
                RUN_LIVE: begin
                    if (frame_start) restart_d = 1'b1;
                end
                default: state_d = RUN_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            restart_q <= 1'b0;
            bank_q    <= '0;
        end else begin
            restart_q <= restart_d;
            if (stop_req) bank_q <= bank_in;
        end
    end

    always_comb begin
        run       = (state_q == RUN_LIVE);
        restart   = restart_q;
        exec_bank = bank_q;
    end

endmodule

// File: rtl/dl_ctrl_regs.sv
module dl_ctrl_regs
    import dl_launch_pkg::*;
#(
    parameter int         ADDR_W  = 4,
    parameter int         START_W = 16,
    parameter logic [4:0] VERSION = 5'd3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_ok,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [7:0]         bus_wdata,
    input  logic [2:0]         vid_std,
    output ctrl_t              ctrl_q,
    output logic [START_W-1:0] start_addr,
    output logic [7:0]         rdata
);

    localparam int N_BYTES    = START_W / 8;
    localparam int OFS_LAUNCH = OFS_START + N_BYTES;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (wr_ok && bus_addr == ADDR_W'(OFS_CTRL))
            ctrl_q <= ctrl_t'(bus_wdata);
    end

    // one byte register per address lane
    for (genvar g = 0; g < N_BYTES; g++) begin : g_start_byte
        logic [7:0] byte_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                byte_q <= '0;
            else if (wr_ok && bus_addr == ADDR_W'(OFS_START + g))
                byte_q <= bus_wdata;
        end
        assign start_addr[g*8 +: 8] = byte_q;
    end

    always_comb begin
        rdata = '0;
        if (bus_addr == ADDR_W'(OFS_CTRL))
            rdata = ctrl_q;
        else if (bus_addr == ADDR_W'(OFS_LAUNCH))
            rdata = {VERSION, vid_std};
        for (int i = 0; i < N_BYTES; i++) begin
            if (bus_addr == ADDR_W'(OFS_START + i))
                rdata = start_addr[i*8 +: 8];
        end
    end

endmodule

// File: rtl/dl_launch_ctrl.sv
module dl_launch_ctrl
    import dl_launch_pkg::*;
#(
    parameter int         ADDR_W  = 4,
    parameter int         START_W = 16,
    parameter logic [4:0] VERSION = 5'd3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_we,
    input  logic [7:0]         bus_wdata,
    output logic [7:0]         bus_rdata,
    input  logic [2:0]         vid_std,
    input  logic               frame_start,
    output logic               eng_run,
    output logic               eng_restart,
    output logic [START_W-1:0] eng_start_addr,
    output logic [BANK_W-1:0]  eng_exec_bank,
    output logic [BANK_W-1:0]  host_bank,
    output logic               port_copy
);

    localparam int N_BYTES    = START_W / 8;
    localparam int OFS_LAUNCH = OFS_START + N_BYTES;

    logic  unlocked_w;
    logic  wr_ctrl, wr_ok, wr_launch_ok, wr_ctrl_ok;
    ctrl_t ctrl_w;

    assign wr_ctrl      = bus_we && bus_addr == ADDR_W'(OFS_CTRL);
    assign wr_ok        = bus_we && unlocked_w;
    assign wr_ctrl_ok   = wr_ok && wr_ctrl;
    assign wr_launch_ok = wr_ok && bus_addr == ADDR_W'(OFS_LAUNCH);

    dl_unlock_fsm u_unlock (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_any   (bus_we),
        .wr_ctrl  (wr_ctrl),
        .wdata    (bus_wdata),
        .unlocked (unlocked_w)
    );

    dl_ctrl_regs #(
        .ADDR_W  (ADDR_W),
        .START_W (START_W),
        .VERSION (VERSION)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_ok      (wr_ok),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .vid_std    (vid_std),
        .ctrl_q     (ctrl_w),
        .start_addr (eng_start_addr),
        .rdata      (bus_rdata)
    );

    dl_run_fsm u_run (
        .clk         (clk),
        .rst_n       (rst_n),
        .stop_req    (wr_ctrl_ok && !bus_wdata[3]),
        .arm_req     (wr_ctrl_ok &&  bus_wdata[3]),
        .launch_req  (wr_launch_ok),
        .frame_start (frame_start),
        .bank_in     (bus_wdata[BANK_W-1:0]),
        .run         (eng_run),
        .restart     (eng_restart),
        .exec_bank   (eng_exec_bank)
    );

    assign host_bank = ctrl_w.bank;
    assign port_copy = (ctrl_w.port_mode == PMODE_COPY);

endmodule

// File: rtl/dl_launch_ctrl_chk.sv
module dl_launch_ctrl_chk
    import dl_launch_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int START_W = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic               bus_we,
    input logic [7:0]         bus_wdata,
    input logic               frame_start,
    input logic               eng_run,
    input logic               eng_restart,
    input logic [START_W-1:0] eng_start_addr,
    input logic [BANK_W-1:0]  eng_exec_bank,
    input logic               port_copy,
    input logic               unlocked
);

    localparam int OFS_LAUNCH = OFS_START + START_W / 8;

    logic stop_wr, launch_wr;
    assign stop_wr   = unlocked && bus_we && bus_addr == ADDR_W'(OFS_CTRL) && !bus_wdata[3];
    assign launch_wr = unlocked && bus_we && bus_addr == ADDR_W'(OFS_LAUNCH);

    assert_locked_inert_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !unlocked |=> ($stable(eng_start_addr) && !eng_run));

    assert_open_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        unlocked |=> unlocked);

    assert_arm_waits_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!eng_run && !frame_start && !launch_wr) |=> !eng_run);

    assert_stop_loads_R6: assert property (@(posedge clk) disable iff (!rst_n)
        stop_wr |=> (!eng_run && eng_exec_bank == $past(bus_wdata[BANK_W-1:0])));

    assert_bank_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !stop_wr |=> $stable(eng_exec_bank));

    assert_launch_next_R8: assert property (@(posedge clk) disable iff (!rst_n)
        launch_wr |=> (eng_run && eng_restart));

    assert_copy_needs_open_R10: assert property (@(posedge clk) disable iff (!rst_n)
        port_copy |-> unlocked);

    assert_restart_in_run_R11: assert property (@(posedge clk) disable iff (!rst_n)
        eng_restart |-> eng_run);

    assert_stop_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_wr && frame_start) |=> !eng_restart);

endmodule

bind dl_launch_ctrl dl_launch_ctrl_chk #(
    .ADDR_W  (ADDR_W),
    .START_W (START_W)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .bus_addr       (bus_addr),
    .bus_we         (bus_we),
    .bus_wdata      (bus_wdata),
    .frame_start    (frame_start),
    .eng_run        (eng_run),
    .eng_restart    (eng_restart),
    .eng_start_addr (eng_start_addr),
    .eng_exec_bank  (eng_exec_bank),
    .port_copy      (port_copy),
    .unlocked       (unlocked_w)
);

// File: tb/tb_dl_launch_ctrl.sv
module tb_dl_launch_ctrl;

    localparam int         CLK_PERIOD = 10;
    localparam int         ADDR_W     = 4;
    localparam int         START_W    = 16;
    localparam logic [4:0] VER        = 5'd3;

    localparam logic [3:0] A_CTRL = 4'd0;
    localparam logic [3:0] A_LO   = 4'd1;
    localparam logic [3:0] A_HI   = 4'd2;
    localparam logic [3:0] A_LNCH = 4'd3;

    logic               clk = 1'b0;
    logic               rst_n;
    logic [ADDR_W-1:0]  bus_addr;
    logic               bus_we;
    logic [7:0]         bus_wdata;
    logic [7:0]         bus_rdata;
    logic [2:0]         vid_std;
    logic               frame_start;
    logic               eng_run, eng_restart, port_copy;
    logic [START_W-1:0] eng_start_addr;
    logic [2:0]         eng_exec_bank, host_bank;

    dl_launch_ctrl #(.ADDR_W(ADDR_W), .START_W(START_W), .VERSION(VER)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .vid_std(vid_std),
        .frame_start(frame_start), .eng_run(eng_run), .eng_restart(eng_restart),
        .eng_start_addr(eng_start_addr), .eng_exec_bank(eng_exec_bank),
        .host_bank(host_bank), .port_copy(port_copy)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef enum {K_RDATA, K_RUN, K_RESTART, K_START, K_EXEC, K_HOST, K_COPY} kind_e;
    typedef struct {
        kind_e       kind;
        logic [15:0] exp;
        string       tag;
    } item_t;

    item_t q[$];
    int    n_checks = 0;
    int    n_err    = 0;
    bit    done     = 1'b0;

    function automatic logic [15:0] observe(kind_e k);
        case (k)
            K_RDATA:   return {8'h00, bus_rdata};
            K_RUN:     return {15'd0, eng_run};
            K_RESTART: return {15'd0, eng_restart};
            K_START:   return eng_start_addr;
            K_EXEC:    return {13'd0, eng_exec_bank};
            K_HOST:    return {13'd0, host_bank};
            default:   return {15'd0, port_copy};
        endcase
    endfunction

    // monitor: compares queued expectations at the falling edge
    always @(negedge clk) begin : mon
        item_t       it;
        logic [15:0] act;
        while (q.size() > 0) begin
            it  = q.pop_front();
            act = observe(it.kind);
            n_checks++;
            if (act !== it.exp) begin
                n_err++;
                $display("FAIL %s %s: actual=%h expected=%h", it.tag, it.kind.name(), act, it.exp);
            end
        end
    end

    task automatic expect_obs(kind_e k, logic [15:0] e, string tag);
        item_t it;
        it.kind = k; it.exp = e; it.tag = tag;
        q.push_back(it);
    endtask

    task automatic flush();
        @(negedge clk); #1;
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic wr(logic [3:0] a, logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        step();
        bus_we = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, logic [7:0] e, string tag);
        bus_addr = a;
        expect_obs(K_RDATA, {8'h00, e}, tag);
        flush();
    endtask

    task automatic pulse_frame();
        frame_start = 1'b1;
        step();
        frame_start = 1'b0;
    endtask

    task automatic run_pair(logic r, logic s, string tag);
        expect_obs(K_RUN, {15'd0, r}, tag);
        expect_obs(K_RESTART, {15'd0, s}, tag);
        flush();
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_err++; n_checks++;
            $display("FAIL R1 watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

    initial begin
        logic [2:0] codes [4];
        codes = '{3'b000, 3'b110, 3'b100, 3'b011};
        rst_n = 1'b0; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0;
        vid_std = 3'b000; frame_start = 1'b0;
        repeat (3) step();
        rst_n = 1'b1;
        step();

        // R1 reset state
        run_pair(1'b0, 1'b0, "R1");
        expect_obs(K_START, 16'h0000, "R1");
        expect_obs(K_EXEC, 16'h0, "R1");
        expect_obs(K_HOST, 16'h0, "R1");
        expect_obs(K_COPY, 16'h0, "R1");
        rd(A_CTRL, 8'h00, "R1");

        // R2 locked: writes ignored, launch ignored
        wr(A_CTRL, 8'h0B);
        rd(A_CTRL, 8'h00, "R2");
        expect_obs(K_HOST, 16'h0, "R2");
        wr(A_LO, 8'h34);
        rd(A_LO, 8'h00, "R2");
        wr(A_LNCH, 8'h00);
        run_pair(1'b0, 1'b0, "R2");

        // R3 broken key sequences
        wr(A_CTRL, 8'h42); wr(A_CTRL, 8'h53); wr(A_CTRL, 8'h52);
        wr(A_CTRL, 8'h05);
        rd(A_CTRL, 8'h00, "R3");
        wr(A_CTRL, 8'h42); wr(A_LO, 8'h11); wr(A_CTRL, 8'h52);
        wr(A_CTRL, 8'h05);
        rd(A_CTRL, 8'h00, "R3");
        rd(A_LO, 8'h00, "R3");

        // R2 proper key; key bytes not stored
        wr(A_CTRL, 8'h42); wr(A_CTRL, 8'h52);
        rd(A_CTRL, 8'h00, "R2");
        wr(A_CTRL, 8'h03);
        rd(A_CTRL, 8'h03, "R4");
        expect_obs(K_HOST, 16'h3, "R4");
        expect_obs(K_EXEC, 16'h3, "R6");
        run_pair(1'b0, 1'b0, "R6");

        // R10 port mode
        wr(A_CTRL, 8'h43); expect_obs(K_COPY, 16'h1, "R10"); flush();
        wr(A_CTRL, 8'h83); expect_obs(K_COPY, 16'h0, "R10"); flush();
        wr(A_CTRL, 8'hC3); expect_obs(K_COPY, 16'h0, "R10"); flush();
        wr(A_CTRL, 8'h03); expect_obs(K_COPY, 16'h0, "R10"); flush();

        // R7 start address
        wr(A_LO, 8'h34); wr(A_HI, 8'h12);
        rd(A_LO, 8'h34, "R7");
        rd(A_HI, 8'h12, "R7");
        expect_obs(K_START, 16'h1234, "R7"); flush();

        // R9 version / timing code readback
        for (int i = 0; i < 4; i++) begin
            vid_std = codes[i];
            rd(A_LNCH, {VER, codes[i]}, "R9");
        end

        // R5 arm waits for frame start
        wr(A_CTRL, 8'h0D);
        expect_obs(K_HOST, 16'h5, "R4");
        expect_obs(K_EXEC, 16'h3, "R6");
        run_pair(1'b0, 1'b0, "R5");
        step(); step();
        run_pair(1'b0, 1'b0, "R5");
        pulse_frame();
        run_pair(1'b1, 1'b1, "R5");
        step();
        run_pair(1'b1, 1'b0, "R5");

        // R11 restart on each frame while running
        step();
        pulse_frame();
        run_pair(1'b1, 1'b1, "R11");
        step();
        run_pair(1'b1, 1'b0, "R11");

        // R6 arm write while live keeps exec bank
        wr(A_CTRL, 8'h0F);
        expect_obs(K_EXEC, 16'h3, "R6");
        run_pair(1'b1, 1'b0, "R6");

        // R6 stop
        wr(A_CTRL, 8'h06);
        expect_obs(K_EXEC, 16'h6, "R6");
        expect_obs(K_HOST, 16'h6, "R4");
        run_pair(1'b0, 1'b0, "R6");
        pulse_frame();
        run_pair(1'b0, 1'b0, "R6");

        // R12 stop in same cycle as frame start
        wr(A_CTRL, 8'h0A);
        bus_addr = A_CTRL; bus_wdata = 8'h01; bus_we = 1'b1; frame_start = 1'b1;
        step();
        bus_we = 1'b0; frame_start = 1'b0;
        expect_obs(K_EXEC, 16'h1, "R12");
        run_pair(1'b0, 1'b0, "R12");

        // R8 launch without arming
        wr(A_LNCH, 8'h00);
        run_pair(1'b1, 1'b1, "R8");
        step();
        run_pair(1'b1, 1'b0, "R8");
        expect_obs(K_START, 16'h1234, "R8");
        expect_obs(K_EXEC, 16'h1, "R6");
        flush();

        // R3 open state persists
        wr(A_CTRL, 8'h02);
        rd(A_CTRL, 8'h02, "R3");

        step();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

endmodule